// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

This block is one channel of a memory-to-memory DMA engine. Software loads five words into it: a source address, a destination address, a link pointer, a control word and a configuration word. Loading the configuration word with its enable bit set arms the channel. Each element is then copied over a simple request/ready memory master port. Each read or write carries a byte size. The control word holds a 12-bit element count, which the engine decrements after every element it copies.

Peripheral request lines gate each element. A flow field in the configuration word chooses whether the element needs the source peripheral's request, the destination peripheral's request, both, or neither. The source and destination element widths can differ. The engine packs narrow reads into one wide write, or splits one wide read into several narrow writes.

When the count reaches zero, a nonzero link pointer makes the engine fetch a four-word descriptor from memory and carry on with the new block. A zero link pointer makes the channel disable itself instead. If the finishing control word requests it, a one-cycle terminal-count pulse is raised.

Top module: `dma_chan_engine`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: every register view (`src_o`, `dst_o`, `link_o`, `ctrl_o`, `cfg_o`), `mem_valid`, `tc_irq` and `busy`.
- R2: The channel starts an element only when all of the following hold: configuration bit 0 is 1, configuration bit 18 is 0, and the flow field (configuration bits 13:11) is in the range 0 to 3. Flow values 4 to 7 start nothing.
- R3: Configuration bits 5:1 select the source request line and bits 10:6 select the destination request line of `req_vec`. The flow field gates each element as follows: 0 needs no request, 1 needs the destination line, 2 needs the source line, and 3 needs both.
- R4: While the count in control bits 11:0 is zero, the engine issues no memory access and leaves the configuration enable bit set.
- R5: Element widths are set by the control word. The source width code is control bits 20:18 and the destination width code is control bits 23:21; `mem_size` carries the code (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes), and codes 3 to 7 act as 4 bytes. One element is max(1, dst/src) source reads followed by max(1, src/dst) destination writes. Read and write data are right-aligned in their buses. Successive reads fill the element buffer from byte 0 upward, and successive writes drain it from byte 0 upward.
- R6: Control bit 26 set makes the source address grow by the source width after each read. Control bit 27 set makes the destination address grow by the destination width after each write. With either bit clear, that address stays fixed.
- R7: Each finished element lowers control bits 11:0 by one. Control bits 31:12 keep their value.
- R8: At count zero with a nonzero link pointer P, the engine makes four 4-byte reads in this order: P+0 (new source), P+4 (new destination), P+12 (new control) and P+8 (new link pointer). It then resumes with the new values.
- R9: At count zero with a zero link pointer, the engine clears configuration bit 0 and leaves every other configuration bit unchanged.
- R10: `tc_irq` is high for exactly one cycle after an element that brings the count to zero, and only if bit 31 of that block's control word was set.
- R11: A request holds `mem_valid`, `mem_addr`, `mem_write` and `mem_size` steady until `mem_ready` is seen. Register loads (`load_sel`: 0 source, 1 destination, 2 link, 3 control, 4 configuration) take effect only while `busy` is low and are ignored otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_valid | input | 1 | Register load strobe |
| load_sel | input | 3 | Register selected for load |
| load_data | input | 32 | Value to load |
| req_vec | input | 32 | Peripheral request lines |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of access |
| mem_size | output | 2 | Log2 of access size in bytes |
| mem_wdata | output | 32 | Right-aligned write data |
| mem_rdata | input | 32 | Right-aligned read data |
| mem_ready | input | 1 | Access completes this cycle |
| tc_irq | output | 1 | Terminal-count pulse |
| busy | output | 1 | Engine in the middle of an element or descriptor fetch |
| src_o | output | 32 | Current source address |
| dst_o | output | 32 | Current destination address |
| link_o | output | 32 | Current link pointer |
| ctrl_o | output | 32 | Current control word |
| cfg_o | output | 32 | Current configuration word |

## Verification
The bench drives mismatched element widths in both directions, plus width codes above the bus size. A packing error would show up as write data with bytes from the wrong beat or at the wrong byte lane. It also runs a channel with the destination increment off. An engine that always advanced the address would then write past a fixed peripheral location. Each flow value is tried with only one of the two request lines raised, to catch a gate that looks at the wrong peripheral field or the wrong line.

A chained run checks the exact descriptor fetch order, including the control word taken from offset 12 before the link from offset 8. It also checks that the terminal-count pulse comes from the finishing control word and not the freshly loaded one. A load issued during a stalled transfer must leave the address views untouched. Without that rule, a software write would corrupt a running element.

// File: rtl/dma_eng_pkg.sv
// Package: dma_eng_pkg
// Shared state encoding and control/configuration field positions for the
// single-channel DMA engine. Assumes a 32-bit data bus and 32-bit words.
package dma_eng_pkg;

    localparam int WORD_W  = 32;
    localparam int REQ_W   = 32;
    localparam int PERI_W  = 5;
    localparam int WCODE_W = 3;
    localparam int SZ_W    = 2;
    localparam int BEAT_W  = 2;

    // configuration word fields
    localparam int CFG_EN     = 0;
    localparam int CFG_SPER   = 1;
    localparam int CFG_DPER   = 6;
    localparam int CFG_FLOW   = 11;
    localparam int CFG_HALT   = 18;

    // control word fields
    localparam int CTL_SW     = 18;
    localparam int CTL_DW     = 21;
    localparam int CTL_SINC   = 26;
    localparam int CTL_DINC   = 27;
    localparam int CTL_TCI    = 31;

    // register load selectors
    localparam logic [2:0] SEL_SRC  = 3'd0;
    localparam logic [2:0] SEL_DST  = 3'd1;
    localparam logic [2:0] SEL_LINK = 3'd2;
    localparam logic [2:0] SEL_CTRL = 3'd3;
    localparam logic [2:0] SEL_CFG  = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DESC  = 2'd3
    } eng_state_t;

endpackage

// File: rtl/dma_req_gate.sv
// Module: dma_req_gate
// Decides whether the channel is live and whether the peripheral request
// lines allow the next element. Purely combinational; assumes the request
// vector has one line per peripheral number.
module dma_req_gate
    import dma_eng_pkg::*;
(
    input  logic              en,
    input  logic              halt,
    input  logic [2:0]        flow,
    input  logic [PERI_W-1:0] src_peri,
    input  logic [PERI_W-1:0] dst_peri,
    input  logic [REQ_W-1:0]  req_vec,
    output logic              chan_live,
    output logic              req_ok
);

    logic src_req;
    logic dst_req;

    // pick the two request lines named by the peripheral fields
    always_comb begin
        src_req = req_vec[src_peri];
        dst_req = req_vec[dst_peri];
    end

    // live only when enabled, not halted, and using a memory-controlled flow
    always_comb begin
        chan_live = en && !halt && !flow[2];
    end

    // flow field selects which request lines must be present
    always_comb begin
        unique case (flow[1:0])
            2'd0:    req_ok = 1'b1;
            2'd1:    req_ok = dst_req;
            2'd2:    req_ok = src_req;
            default: req_ok = src_req && dst_req;
        endcase
    end

endmodule

// File: rtl/dma_width_plan.sv
// Module: dma_width_plan
// Turns the source and destination width codes into bus size codes and the
// index of the last read and last write beat of one element. Codes beyond
// the bus width are clamped to a full word.
module dma_width_plan
    import dma_eng_pkg::*;
(
    input  logic [WCODE_W-1:0] src_code,
    input  logic [WCODE_W-1:0] dst_code,
    output logic [SZ_W-1:0]    src_sz,
    output logic [SZ_W-1:0]    dst_sz,
    output logic [BEAT_W-1:0]  rd_last,
    output logic [BEAT_W-1:0]  wr_last
);

    localparam logic [SZ_W-1:0] MAX_SZ = SZ_W'($clog2(WORD_W / 8));

    // clamp both width codes to the bus width
    always_comb begin
        src_sz = (src_code > WCODE_W'(MAX_SZ)) ? MAX_SZ : src_code[SZ_W-1:0];
        dst_sz = (dst_code > WCODE_W'(MAX_SZ)) ? MAX_SZ : dst_code[SZ_W-1:0];
    end

    // narrow side repeats until the wide side is filled or drained
    always_comb begin
        rd_last = '0;
        wr_last = '0;
        if (dst_sz > src_sz)
            rd_last = BEAT_W'((3'd1 << (dst_sz - src_sz)) - 3'd1);
        if (src_sz > dst_sz)
            wr_last = BEAT_W'((3'd1 << (src_sz - dst_sz)) - 3'd1);
    end

endmodule

// File: rtl/dma_elem_buf.sv
// Module: dma_elem_buf
// One-word element buffer. Read beats land at byte offset beat*src_bytes;
// write beats take bytes from offset beat*dst_bytes, right-aligned.
// Assumes beat indices never run past the end of the word.
module dma_elem_buf
    import dma_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill,
    input  logic [BEAT_W-1:0] rd_beat,
    input  logic [SZ_W-1:0]   src_sz,
    input  logic [WORD_W-1:0] rdata,
    input  logic [BEAT_W-1:0] wr_beat,
    input  logic [SZ_W-1:0]   dst_sz,
    output logic [WORD_W-1:0] wdata
);

    localparam int NBYTES = WORD_W / 8;

    logic [WORD_W-1:0] buf_q;
    logic [BEAT_W-1:0] rd_off;
    logic [BEAT_W-1:0] wr_off;

    // byte offsets of the current read and write beats
    always_comb begin
        rd_off = BEAT_W'(rd_beat << src_sz);
        wr_off = BEAT_W'(wr_beat << dst_sz);
    end

    // capture the read lanes of this beat into their place in the buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (fill) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (b >= int'(rd_off) && (b - int'(rd_off)) < (1 << src_sz))
                    buf_q[b*8 +: 8] <= rdata[(b - int'(rd_off))*8 +: 8];
            end
        end
    end

    // shift the selected write lanes down to bit 0
    always_comb begin
        wdata = buf_q >> {wr_off, 3'b000};
    end

endmodule

// File: rtl/dma_chan_engine.sv
// Module: dma_chan_engine
// Single DMA channel: copies elements from source to destination over a
// ready-handshake memory port, gated by peripheral requests, reloads its
// registers from a descriptor chain at count zero, and pulses a
// terminal-count interrupt. Assumes memory data is right-aligned and that
// loads are only meaningful while idle.
module dma_chan_engine
    import dma_eng_pkg::*;
#(
    parameter int CNT_W = 12
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [2:0]        load_sel,
    input  logic [WORD_W-1:0] load_data,
    input  logic [REQ_W-1:0]  req_vec,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [WORD_W-1:0] mem_addr,
    output logic [SZ_W-1:0]   mem_size,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              tc_irq,
    output logic              busy,
    output logic [WORD_W-1:0] src_o,
    output logic [WORD_W-1:0] dst_o,
    output logic [WORD_W-1:0] link_o,
    output logic [WORD_W-1:0] ctrl_o,
    output logic [WORD_W-1:0] cfg_o
);

    localparam logic [SZ_W-1:0] WORD_SZ = SZ_W'($clog2(WORD_W / 8));

    eng_state_t        st;
    logic [BEAT_W-1:0] beat;
    logic [WORD_W-1:0] src_q, dst_q, lli_q, ctrl_q, cfg_q;
    logic              tc_q;

    logic              chan_live, req_ok, go;
    logic [SZ_W-1:0]   src_sz, dst_sz;
    logic [BEAT_W-1:0] rd_last, wr_last;
    logic [WORD_W-1:0] buf_wdata;
    logic [CNT_W-1:0]  cnt, cnt_next;
    logic [3:0]        desc_off;
    logic              elem_done;

    dma_req_gate u_gate (
        .en        (cfg_q[CFG_EN]),
        .halt      (cfg_q[CFG_HALT]),
        .flow      (cfg_q[CFG_FLOW +: 3]),
        .src_peri  (cfg_q[CFG_SPER +: PERI_W]),
        .dst_peri  (cfg_q[CFG_DPER +: PERI_W]),
        .req_vec   (req_vec),
        .chan_live (chan_live),
        .req_ok    (req_ok)
    );

    dma_width_plan u_width (
        .src_code (ctrl_q[CTL_SW +: WCODE_W]),
        .dst_code (ctrl_q[CTL_DW +: WCODE_W]),
        .src_sz   (src_sz),
        .dst_sz   (dst_sz),
        .rd_last  (rd_last),
        .wr_last  (wr_last)
    );

    dma_elem_buf u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .fill    (st == ST_READ && mem_ready),
        .rd_beat (beat),
        .src_sz  (src_sz),
        .rdata   (mem_rdata),
        .wr_beat (beat),
        .dst_sz  (dst_sz),
        .wdata   (buf_wdata)
    );

    // count view, start condition and element completion
    always_comb begin
        cnt       = ctrl_q[CNT_W-1:0];
        cnt_next  = cnt - 1'b1;
        go        = chan_live && req_ok && (cnt != '0);
        elem_done = (st == ST_WRITE) && mem_ready && (beat == wr_last);
    end

    // descriptor word order: source, destination, control, then link
    always_comb begin
        unique case (beat)
            2'd0:    desc_off = 4'd0;
            2'd1:    desc_off = 4'd4;
            2'd2:    desc_off = 4'd12;
            default: desc_off = 4'd8;
        endcase
    end

    // channel registers and transfer sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            beat   <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            lli_q  <= '0;
            ctrl_q <= '0;
            cfg_q  <= '0;
            tc_q   <= 1'b0;
        end else begin
            tc_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (load_valid) begin
                        case (load_sel)
                            SEL_SRC:  src_q  <= load_data;
                            SEL_DST:  dst_q  <= load_data;
                            SEL_LINK: lli_q  <= load_data;
                            SEL_CTRL: ctrl_q <= load_data;
                            SEL_CFG:  cfg_q  <= load_data;
                            default:  ;
                        endcase
                    end else if (go) begin
                        st   <= ST_READ;
                        beat <= '0;
                    end
                end
                ST_READ: begin
                    if (mem_ready) begin
                        if (ctrl_q[CTL_SINC])
                            src_q <= src_q + (WORD_W'(1) << src_sz);
                        if (beat == rd_last) begin
                            st   <= ST_WRITE;
                            beat <= '0;
                        end else begin
                            beat <= beat + 1'b1;
                        end
                    end
                end
                ST_WRITE: begin
                    if (mem_ready) begin
                        if (ctrl_q[CTL_DINC])
                            dst_q <= dst_q + (WORD_W'(1) << dst_sz);
                        if (beat == wr_last) begin
                            beat              <= '0;
                            ctrl_q[CNT_W-1:0] <= cnt_next;
                            if (cnt_next == '0) begin
                                tc_q <= ctrl_q[CTL_TCI];
                                if (lli_q != '0) begin
                                    st <= ST_DESC;
                                end else begin
                                    cfg_q[CFG_EN] <= 1'b0;
                                    st            <= ST_IDLE;
                                end
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else begin
                            beat <= beat + 1'b1;
                        end
                    end
                end
                ST_DESC: begin
                    if (mem_ready) begin
                        case (beat)
                            2'd0: src_q  <= mem_rdata;
                            2'd1: dst_q  <= mem_rdata;
                            2'd2: ctrl_q <= mem_rdata;
                            default: begin
                                lli_q <= mem_rdata;
                                st    <= ST_IDLE;
                            end
                        endcase
                        beat <= beat + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // memory master drive from the current state
    always_comb begin
        mem_valid = (st != ST_IDLE);
        mem_write = (st == ST_WRITE);
        mem_addr  = '0;
        mem_size  = '0;
        mem_wdata = '0;
        unique case (st)
            ST_READ: begin
                mem_addr = src_q;
                mem_size = src_sz;
            end
            ST_WRITE: begin
                mem_addr  = dst_q;
                mem_size  = dst_sz;
                mem_wdata = buf_wdata;
            end
            ST_DESC: begin
                mem_addr = lli_q + WORD_W'(desc_off);
                mem_size = WORD_SZ;
            end
            default: ;
        endcase
    end

    // register views and status
    always_comb begin
        tc_irq = tc_q;
        busy   = (st != ST_IDLE);
        src_o  = src_q;
        dst_o  = dst_q;
        link_o = lli_q;
        ctrl_o = ctrl_q;
        cfg_o  = cfg_q;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_size))); // R11
    AST_TC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tc_irq |=> !tc_irq); // R10
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        elem_done |=> (ctrl_q[CNT_W-1:0] == $past(ctrl_q[CNT_W-1:0]) - 1'b1) && (ctrl_q[WORD_W-1:CNT_W] == $past(ctrl_q[WORD_W-1:CNT_W]))); // R7
    AST_ZERO_COUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && cnt == '0) |=> !mem_valid); // R4
    AST_DEAD_CHAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !chan_live) |=> !mem_valid); // R2

endmodule

// File: tb/dma_chan_engine_bench.sv
`timescale 1ns/1ps
module dma_chan_engine_bench;

    localparam logic [31:0] B_TCI  = 32'h8000_0000;
    localparam logic [31:0] B_DINC = 32'h0800_0000;
    localparam logic [31:0] B_SINC = 32'h0400_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_valid = 1'b0;
    logic [2:0]  load_sel = 3'd0;
    logic [31:0] load_data = 32'd0;
    logic [31:0] req_vec = 32'd0;
    logic        mem_valid, mem_write;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic [31:0] mem_rdata = 32'd0;
    logic        mem_ready = 1'b0;
    logic        tc_irq, busy;
    logic [31:0] src_o, dst_o, link_o, ctrl_o, cfg_o;

    always #2.5 clk = ~clk;

    dma_chan_engine u_dma_chan_engine (
        .clk(clk), .rst_n(rst_n),
        .load_valid(load_valid), .load_sel(load_sel), .load_data(load_data),
        .req_vec(req_vec),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .tc_irq(tc_irq), .busy(busy),
        .src_o(src_o), .dst_o(dst_o), .link_o(link_o), .ctrl_o(ctrl_o), .cfg_o(cfg_o)
    );

    typedef struct {
        bit          wr;
        logic [31:0] addr;
        logic [1:0]  sz;
        logic [31:0] data;
    } acc_t;

    acc_t        exp_q[$];
    logic [7:0]  mem [0:4095];
    int          errors = 0;
    int          checks = 0;
    int          tc_seen = 0;
    int          tc_exp = 0;
    bit          slow = 1'b0;
    int          stall_cnt = 0;
    string       cur_tag = "R1";
    logic [31:0] m_src, m_dst, m_lli, m_ctrl, m_cfg;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_mem(input logic [31:0] a, input logic [1:0] sz);
        logic [31:0] r = '0;
        for (int b = 0; b < (1 << sz); b++) r[8*b +: 8] = mem[12'(a + b)];
        return r;
    endfunction

    task automatic wr_word(input logic [31:0] a, input logic [31:0] v);
        for (int b = 0; b < 4; b++) mem[12'(a + b)] = v[8*b +: 8];
    endtask

    function automatic int szl(input logic [2:0] c);
        return (c > 3'd2) ? 2 : int'(c);
    endfunction

    function automatic logic [31:0] mk_ctrl(input logic [31:0] flags, input int dw,
                                            input int sw, input int cnt);
        return flags | (32'(dw) << 21) | (32'(sw) << 18) | 32'(cnt);
    endfunction

    // behavioural model: plans every access until the channel stops
    task automatic plan();
        int ssz, dsz, nrd, nwr;
        logic [31:0] b, wd, p;
        while (m_ctrl[11:0] != 12'd0) begin
            ssz = szl(m_ctrl[20:18]);
            dsz = szl(m_ctrl[23:21]);
            nrd = (dsz > ssz) ? (1 << (dsz - ssz)) : 1;
            nwr = (ssz > dsz) ? (1 << (ssz - dsz)) : 1;
            b = '0;
            for (int k = 0; k < nrd; k++) begin
                exp_q.push_back('{1'b0, m_src, 2'(ssz), 32'd0});
                b = b | (rd_mem(m_src, 2'(ssz)) << (k * (8 << ssz)));
                if (m_ctrl[26]) m_src = m_src + (32'd1 << ssz);
            end
            for (int j = 0; j < nwr; j++) begin
                wd = b >> (j * (8 << dsz));
                exp_q.push_back('{1'b1, m_dst, 2'(dsz), wd});
                if (m_ctrl[27]) m_dst = m_dst + (32'd1 << dsz);
            end
            m_ctrl[11:0] = m_ctrl[11:0] - 12'd1;
            if (m_ctrl[11:0] == 12'd0) begin
                if (m_ctrl[31]) tc_exp++;
                if (m_lli != 32'd0) begin
                    p = m_lli;
                    exp_q.push_back('{1'b0, p,         2'd2, 32'd0});
                    exp_q.push_back('{1'b0, p + 32'd4, 2'd2, 32'd0});
                    exp_q.push_back('{1'b0, p + 32'd12, 2'd2, 32'd0});
                    exp_q.push_back('{1'b0, p + 32'd8, 2'd2, 32'd0});
                    m_src  = rd_mem(p, 2'd2);
                    m_dst  = rd_mem(p + 32'd4, 2'd2);
                    m_ctrl = rd_mem(p + 32'd12, 2'd2);
                    m_lli  = rd_mem(p + 32'd8, 2'd2);
                end else begin
                    m_cfg[0] = 1'b0;
                end
            end
        end
    endtask

    // memory responder, compares every accepted access with the model
    always @(negedge clk) begin
        acc_t h;
        logic [31:0] mask;
        mem_ready = 1'b0;
        if (rst_n && mem_valid) begin
            if (slow && stall_cnt < 2) begin
                stall_cnt++;
            end else begin
                stall_cnt = 0;
                mem_ready = 1'b1;
                if (exp_q.size() == 0) begin
                    chk(1'b0, cur_tag, "unexpected access addr", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    h = exp_q.pop_front();
                    chk(mem_write == h.wr && mem_addr == h.addr && mem_size == h.sz,
                        cur_tag, "access addr", mem_addr, h.addr);
                    if (h.wr) begin
                        mask = (h.sz == 2'd2) ? 32'hFFFF_FFFF : ((32'd1 << (8 << h.sz)) - 1);
                        chk((mem_wdata & mask) == (h.data & mask), cur_tag, "write data",
                            mem_wdata & mask, h.data & mask);
                    end
                end
                if (mem_write) begin
                    for (int b = 0; b < (1 << mem_size); b++) mem[12'(mem_addr + b)] = mem_wdata[8*b +: 8];
                end else begin
                    mem_rdata = rd_mem(mem_addr, mem_size);
                end
            end
        end
    end

    always @(negedge clk) if (rst_n && tc_irq) tc_seen++;

    task automatic load(input logic [2:0] sel, input logic [31:0] v);
        @(negedge clk);
        load_valid = 1'b1;
        load_sel   = sel;
        load_data  = v;
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    task automatic program_chan(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l,
                                input logic [31:0] c, input logic [31:0] f, input bit do_plan);
        load(3'd0, s); load(3'd1, d); load(3'd2, l); load(3'd3, c);
        m_src = s; m_dst = d; m_lli = l; m_ctrl = c; m_cfg = f;
        if (do_plan) plan();
        load(3'd4, f);
    endtask

    task automatic wait_done();
        int n = 0;
        @(negedge clk);
        while ((exp_q.size() != 0 || busy) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, cur_tag, "model accesses left", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic check_views();
        chk(src_o == m_src,   cur_tag, "source view", src_o, m_src);
        chk(dst_o == m_dst,   cur_tag, "destination view", dst_o, m_dst);
        chk(ctrl_o == m_ctrl, cur_tag, "control view", ctrl_o, m_ctrl);
        chk(cfg_o == m_cfg,   cur_tag, "configuration view", cfg_o, m_cfg);
        chk(32'(tc_seen) == 32'(tc_exp), cur_tag, "terminal-count pulses", 32'(tc_seen), 32'(tc_exp));
    endtask

    task automatic quiet(input int n, input logic [31:0] c_exp);
        repeat (n) @(negedge clk);
        chk(!busy, cur_tag, "engine stays idle", 32'(busy), 32'd0);
        chk(ctrl_o == c_exp, cur_tag, "count untouched", ctrl_o, c_exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] c;
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        cur_tag = "R1";
        chk(!mem_valid && !tc_irq && !busy, "R1", "idle outputs", {mem_valid, tc_irq, busy}, 32'd0);
        chk(src_o == 0 && dst_o == 0 && link_o == 0, "R1", "address views", src_o | dst_o | link_o, 32'd0);
        chk(ctrl_o == 0 && cfg_o == 0, "R1", "word views", ctrl_o | cfg_o, 32'd0);

        // R6 R7 R9 R10: word copy with both increments and interrupt
        cur_tag = "R7";
        program_chan(32'h100, 32'h400, 32'h0, mk_ctrl(B_TCI | B_DINC | B_SINC, 2, 2, 3), 32'h1, 1);
        wait_done();
        check_views();

        // R5 byte reads packed into word writes
        cur_tag = "R5";
        program_chan(32'h120, 32'h480, 32'h0, mk_ctrl(B_DINC | B_SINC, 2, 0, 2), 32'h1, 1);
        wait_done();
        check_views();

        // R5 word reads split into halfword writes
        program_chan(32'h140, 32'h4A0, 32'h0, mk_ctrl(B_DINC | B_SINC, 1, 2, 2), 32'h1, 1);
        wait_done();
        check_views();

        // R5 width codes above the bus clamp to four bytes
        program_chan(32'h150, 32'h4B0, 32'h0, mk_ctrl(B_DINC | B_SINC | B_TCI, 7, 5, 1), 32'h1, 1);
        wait_done();
        check_views();

        // R6 fixed destination, R11 stalled handshake and load while busy
        cur_tag = "R11";
        slow = 1'b1;
        program_chan(32'h160, 32'h4C0, 32'h0, mk_ctrl(B_SINC, 2, 2, 3), 32'h1, 1);
        while (!busy) @(negedge clk);
        load(3'd0, 32'hDEAD_0000);
        load(3'd1, 32'hBEEF_0000);
        wait_done();
        slow = 1'b0;
        chk(dst_o == 32'h4C0, "R6", "destination held", dst_o, 32'h4C0);
        check_views();

        // R3 flow 3 needs both lines
        cur_tag = "R3";
        c = mk_ctrl(B_DINC | B_SINC, 2, 2, 2);
        req_vec = 32'd1 << 5;
        program_chan(32'h170, 32'h500, 32'h0, c, 32'h1 | (32'd5 << 1) | (32'd9 << 6) | (32'd3 << 11), 0);
        quiet(30, c);
        plan();
        req_vec = (32'd1 << 5) | (32'd1 << 9);
        wait_done();
        check_views();

        // R3 flow 1 needs the destination line only
        req_vec = 32'd1 << 5;
        program_chan(32'h180, 32'h520, 32'h0, c, 32'h1 | (32'd5 << 1) | (32'd9 << 6) | (32'd1 << 11), 0);
        quiet(20, c);
        plan();
        req_vec = 32'd1 << 9;
        wait_done();
        check_views();

        // R3 flow 2 needs the source line only
        program_chan(32'h190, 32'h540, 32'h0, c, 32'h1 | (32'd5 << 1) | (32'd9 << 6) | (32'd2 << 11), 0);
        quiet(20, c);
        plan();
        req_vec = 32'd1 << 5;
        wait_done();
        check_views();

        // R2 flow 6 and halt keep the channel idle
        cur_tag = "R2";
        req_vec = 32'hFFFF_FFFF;
        program_chan(32'h1A0, 32'h560, 32'h0, c, 32'h1 | (32'd6 << 11), 0);
        quiet(20, c);
        chk(cfg_o[0] == 1'b1, "R2", "enable kept", cfg_o, 32'h1 | (32'd6 << 11));
        program_chan(32'h1A0, 32'h560, 32'h0, c, 32'h1 | (32'd1 << 18), 0);
        quiet(20, c);
        load(3'd4, 32'h0);

        // R4 zero count does nothing
        cur_tag = "R4";
        c = mk_ctrl(B_TCI | B_SINC, 2, 2, 0);
        program_chan(32'h1B0, 32'h570, 32'h0, c, 32'h1, 0);
        quiet(20, c);
        chk(cfg_o[0] == 1'b1 && 32'(tc_seen) == 32'(tc_exp), "R4", "enable and pulses", cfg_o, 32'h1);
        load(3'd4, 32'h0);

        // R8 R9 R10 chained descriptor
        cur_tag = "R8";
        req_vec = 32'd0;
        wr_word(32'h300, 32'h1C0);
        wr_word(32'h304, 32'h580);
        wr_word(32'h308, 32'h0);
        wr_word(32'h30C, mk_ctrl(B_TCI | B_DINC | B_SINC, 2, 2, 2));
        program_chan(32'h1E0, 32'h5C0, 32'h300, mk_ctrl(B_DINC | B_SINC, 2, 2, 1), 32'h1, 1);
        wait_done();
        check_views();
        chk(link_o == 32'h0, "R8", "link view", link_o, 32'h0);
        chk(cfg_o == 32'h0, "R9", "enable cleared after chain", cfg_o, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule